// File: doc/BRIEF.md
# Comma Detect and Word Aligner

This block takes a recovered serial bit stream, one bit per clock with the earliest bit of each character arriving first, and cuts it into 10-bit parallel words. It searches the stream for the seven-bit comma sequence of 8b/10b control characters, in either running disparity, and moves its word boundary so that the character holding the comma fills one whole output word. Each output word comes with a flag that is high when that word holds a comma sitting exactly on the word boundary.

Two byte strobes run at half the word rate in opposite phase. One is high while an even-numbered word is on the output and the other while an odd-numbered word is there, so a downstream protocol device can register alternate words on alternate strobes. A realignment may lengthen the current strobe level but never cuts it short.

The align-enable input decides whether every comma may move the boundary. With it low, the block aligns only once, to the first comma seen since reset, and then keeps its boundary. Nothing is detected or aligned while the receiver-locked input is low.

Top module: `comma_word_aligner`

## Requirements
- R1: A comma is present when the seven earliest-received bits of a 10-bit window, in receive order, are 0,0,1,1,1,1,1 or 1,1,0,0,0,0,0; this covers K28.1, K28.5 and K28.7 in both disparities (in bit-0-first value form K28.5 is 0x17C or 0x283, K28.1 is 0x27C, K28.7 is 0x07C).
- R2: Bit 0 of `rx_word` is the earliest-received bit of the word, bit 9 the latest; an aligned character appears on `rx_word` with exactly its 10-bit value, and the following characters follow it word by word.
- R3: With `align_en` high, a comma found off the current boundary moves the boundary so that its character is output as one word.
- R4: `comma_flag` is 1 for exactly those output words whose bits [6:0] hold a comma (R1), with either setting of `align_en`, and 0 for all other words.
- R5: With `align_en` low after alignment has been achieved, a comma off the boundary does not move it and produces no flagged word.
- R6: With `align_en` low and no alignment achieved since reset, the block aligns to the first comma only; a later off-boundary comma is ignored and not flagged.
- R7: `strb_even` and `strb_odd` are always complementary; they swap on every new output word, and the first word after reset is even (`strb_even` = 1).
- R8: Each strobe level lasts at least 10 clocks; a realignment only lengthens it (up to 19 clocks).
- R9: While `rx_lock` is 0, no comma is detected: no word is flagged and the boundary does not move.
- R10: Synchronous active-low reset clears the output word to 0, the flag to 0, sets `strb_even` = 0, `strb_odd` = 1, and forgets any earlier alignment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_bit | input | 1 | Recovered serial data bit |
| rx_lock | input | 1 | Receiver locked; gates comma detection and alignment |
| align_en | input | 1 | 1: align on every comma; 0: align only once |
| rx_word | output | 10 | Parallel output word, bit 0 earliest received |
| comma_flag | output | 1 | Current word holds a byte-aligned comma |
| strb_even | output | 1 | High while an even-numbered word is output |
| strb_odd | output | 1 | High while an odd-numbered word is output |

## Verification
On every cycle the assertions check that the strobes stay complementary, that a new word always swaps them, that no strobe level is shorter than one word time, that a raised flag only ever accompanies a word whose low seven bits form a comma and a locked receiver, that the alignment memory never clears outside reset, and the reset values. Whether the boundary actually lands on the comma, whether a misaligned comma is left alone under each enable setting, that only the first comma counts when alignment was never reached, and that the word contents come out in the right bit order can only be shown by the bench's scenarios, which feed chosen character streams at chosen bit offsets and compare the collected words.

// File: rtl/cda_pkg.sv
// Package: shared constants and helpers of the comma detect and word aligner.
// Assumes 8b/10b characters with bit 0 received first.
package cda_pkg;

    // Width of a parallel character and of the comma sequence.
    localparam int CHAR_W  = 10;
    localparam int COMMA_W = 7;
    // Number of comma polarities searched for.
    localparam int NUM_PAT = 2;

    // Comma sequence for negative disparity, bit 0 = first received: 0,0,1,1,1,1,1.
    localparam logic [COMMA_W-1:0] COMMA_NEG = 7'b1111100;

    // Returns the comma pattern for a given polarity index (0: negative, 1: positive).
    function automatic logic [COMMA_W-1:0] comma_pattern(input int idx);
        return (idx == 0) ? COMMA_NEG : ~COMMA_NEG;
    endfunction

endpackage

// File: rtl/cda_shifter.sv
// Module: serial-in shift register holding two consecutive character windows.
// The newest bit enters at the top, so each window has its earliest bit at
// its lowest index. Assumes one valid bit per clock.
module cda_shifter #(
    parameter int WORD_W = cda_pkg::CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    output logic [WORD_W-1:0] win_new,
    output logic [WORD_W-1:0] win_old
);
    localparam int SR_W = 2 * WORD_W;

    logic [SR_W-1:0] sr_q;

    // Shift the stream in, newest bit at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= {ser_bit, sr_q[SR_W-1:1]};
        end
    end

    assign win_new = sr_q[SR_W-1:WORD_W];
    assign win_old = sr_q[WORD_W-1:0];

endmodule

// File: rtl/cda_comma_match.sv
// Module: combinational comma matcher. Compares the earliest-received bits
// of a window against every comma polarity. Assumes the slice given holds
// the first COMMA_W bits of a character, bit 0 first.
module cda_comma_match #(
    parameter int COMMA_W = cda_pkg::COMMA_W,
    parameter int NUM_PAT = cda_pkg::NUM_PAT
) (
    input  logic [COMMA_W-1:0] head,
    output logic               hit
);
    logic [NUM_PAT-1:0] pat_hit;

    // One comparator per polarity.
    for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
        assign pat_hit[p] = (head == cda_pkg::comma_pattern(p));
    end

    // Any polarity counts as a comma.
    assign hit = |pat_hit;

endmodule

// File: rtl/cda_align_ctrl.sv
// Module: word boundary control. Keeps the bit phase counter and the
// alignment memory, decides when a comma in the newest window moves the
// boundary. A comma seen in the newest window reaches the older window one
// word later, so a moved boundary always lengthens the word interval.
module cda_align_ctrl #(
    parameter int WORD_W = cda_pkg::CHAR_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic comma_new,
    input  logic rx_lock,
    input  logic align_en,
    output logic emit,
    output logic aligned
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] phase_q;
    logic             hist_q;
    logic             detect;
    logic             may_align;
    logic             on_bound;
    logic             realign;

    // Decide whether the comma in view may and must move the boundary.
    always_comb begin
        detect    = rx_lock && comma_new;
        may_align = align_en || !hist_q;
        on_bound  = (phase_q == LAST);
        realign   = detect && may_align && !on_bound;
    end

    // Bit phase counter: wraps at a word end, restarts on realignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (realign || on_bound) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Alignment memory: set once a permitted comma has fixed the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= 1'b0;
        end else if (detect && may_align) begin
            hist_q <= 1'b1;
        end
    end

    assign emit    = on_bound;
    assign aligned = hist_q;

endmodule

// File: rtl/cda_word_out.sv
// Module: output register. Captures a finished word with its comma flag and
// toggles the word parity that drives the two byte strobes. Assumes the
// flag input is already gated by the receiver lock.
module cda_word_out #(
    parameter int WORD_W = cda_pkg::CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  logic [WORD_W-1:0] word_in,
    input  logic              flag_in,
    output logic [WORD_W-1:0] word_q,
    output logic              flag_q,
    output logic              even_q,
    output logic              odd_q
);
    logic par_q;

    // Load a new word and its flag at each word end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            flag_q <= 1'b0;
        end else if (emit) begin
            word_q <= word_in;
            flag_q <= flag_in;
        end
    end

    // Word parity: 1 after reset so that the first word is even.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= 1'b1;
        end else if (emit) begin
            par_q <= !par_q;
        end
    end

    assign even_q = !par_q;
    assign odd_q  = par_q;

endmodule

// File: rtl/comma_word_aligner.sv
// Module: comma detect and word aligner top. Serial bits in, 10-bit words
// out with an aligned-comma flag and two opposite-phase byte strobes.
// Assumes one recovered bit per clock, earliest bit of a character first.
module comma_word_aligner #(
    parameter int WORD_W  = cda_pkg::CHAR_W,
    parameter int COMMA_W = cda_pkg::COMMA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic              rx_lock,
    input  logic              align_en,
    output logic [WORD_W-1:0] rx_word,
    output logic              comma_flag,
    output logic              strb_even,
    output logic              strb_odd
);
    logic [WORD_W-1:0] win_new;
    logic [WORD_W-1:0] win_old;
    logic              comma_new;
    logic              comma_old;
    logic              emit;
    logic              aligned_hist;

    // Two-window shift register.
    cda_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_bit (ser_bit),
        .win_new (win_new),
        .win_old (win_old)
    );

    // Comma search in the newest window, for boundary control.
    cda_comma_match #(.COMMA_W(COMMA_W)) u_match_new (
        .head (win_new[COMMA_W-1:0]),
        .hit  (comma_new)
    );

    // Comma check in the outgoing window, for the flag.
    cda_comma_match #(.COMMA_W(COMMA_W)) u_match_old (
        .head (win_old[COMMA_W-1:0]),
        .hit  (comma_old)
    );

    // Boundary and alignment memory.
    cda_align_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .comma_new (comma_new),
        .rx_lock   (rx_lock),
        .align_en  (align_en),
        .emit      (emit),
        .aligned   (aligned_hist)
    );

    // Output register and strobes.
    cda_word_out #(.WORD_W(WORD_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .emit    (emit),
        .word_in (win_old),
        .flag_in (comma_old && rx_lock),
        .word_q  (rx_word),
        .flag_q  (comma_flag),
        .even_q  (strb_even),
        .odd_q   (strb_odd)
    );

endmodule

// File: rtl/comma_word_aligner_chk.sv
// Module: assertion checker for the comma detect and word aligner, bound to
// the top. Assumes the default 10-bit word and 7-bit comma.
module comma_word_aligner_chk #(
    parameter int WORD_W = cda_pkg::CHAR_W,
    parameter int HOLD_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_lock,
    input logic [WORD_W-1:0] rx_word,
    input logic              comma_flag,
    input logic              strb_even,
    input logic              strb_odd,
    input logic              aligned_hist
);
    localparam logic [HOLD_W-1:0] HOLD_MAX = '1;
    localparam logic [6:0] PAT_N = 7'b1111100;
    localparam logic [6:0] PAT_P = 7'b0000011;

    logic              prev_even_q;
    logic [HOLD_W-1:0] hold_q;
    logic              in_rst_q;

    // Count how long the even strobe has held its level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_even_q <= 1'b0;
            hold_q      <= '0;
        end else begin
            prev_even_q <= strb_even;
            if (strb_even != prev_even_q) begin
                hold_q <= '0;
            end else if (hold_q != HOLD_MAX) begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end

    // A level may only end after a full word time.
    always_ff @(posedge clk) begin
        if (rst_n && strb_even != prev_even_q) begin
            AST_STRB_MIN_LEVEL: assert (hold_q >= HOLD_W'(WORD_W - 1)); // R8
        end
    end

    // Remember that the previous cycle was in reset.
    always_ff @(posedge clk) begin
        in_rst_q <= !rst_n;
        if (in_rst_q) begin
            AST_RESET_STATE: assert (rx_word == '0 && !comma_flag && !strb_even && strb_odd); // R10
        end
    end

    AST_STRB_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
        strb_even != strb_odd); // R7

    AST_WORD_SWAPS_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_word) |-> !$stable(strb_even)); // R7

    AST_FLAG_HOLDS_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        comma_flag |-> (rx_word[6:0] == PAT_N || rx_word[6:0] == PAT_P)); // R4

    AST_FLAG_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(comma_flag) |-> $past(rx_lock)); // R9

    AST_HIST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        aligned_hist |=> aligned_hist); // R6

endmodule

bind comma_word_aligner comma_word_aligner_chk #(.WORD_W(WORD_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_lock      (rx_lock),
    .rx_word      (rx_word),
    .comma_flag   (comma_flag),
    .strb_even    (strb_even),
    .strb_odd     (strb_odd),
    .aligned_hist (aligned_hist)
);

// File: tb/test_comma_word_aligner.sv
// Directed bench for the comma detect and word aligner.
module test_comma_word_aligner;
    localparam int CLK_PERIOD = 10;
    localparam int CAP_N      = 2048;

    localparam logic [9:0] K285N = 10'h17C;
    localparam logic [9:0] K285P = 10'h283;
    localparam logic [9:0] K281N = 10'h27C;
    localparam logic [9:0] K287N = 10'h07C;
    localparam logic [9:0] D215  = 10'h155;
    localparam logic [9:0] D102  = 10'h2AA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b0;
    logic       rx_lock = 1'b1;
    logic       align_en = 1'b1;
    logic [9:0] rx_word;
    logic       comma_flag;
    logic       strb_even;
    logic       strb_odd;

    int n_checks = 0;
    int n_errors = 0;

    logic [9:0] cap_w [CAP_N];
    logic       cap_f [CAP_N];
    logic       cap_e [CAP_N];
    int  cap_n = 0;
    int  since_chg = 0;
    int  max_gap = 0;
    int  short_gaps = 0;
    int  opp_errs = 0;
    logic prev_even = 1'b0;

    comma_word_aligner i_comma_word_aligner (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_bit    (ser_bit),
        .rx_lock    (rx_lock),
        .align_en   (align_en),
        .rx_word    (rx_word),
        .comma_flag (comma_flag),
        .strb_even  (strb_even),
        .strb_odd   (strb_odd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: collect every new word at the falling edge, time strobe levels.
    always @(negedge clk) begin
        if (strb_even == strb_odd) opp_errs++;
        if (rst_n && strb_even != prev_even) begin
            if (cap_n < CAP_N) begin
                cap_w[cap_n] = rx_word;
                cap_f[cap_n] = comma_flag;
                cap_e[cap_n] = strb_even;
                cap_n++;
            end
            if (since_chg < 10) short_gaps++;
            if (since_chg > max_gap) max_gap = since_chg;
            since_chg = 1;
        end else begin
            since_chg++;
        end
        prev_even = strb_even;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int find_word(input int from, input logic [9:0] val);
        for (int i = from; i < cap_n; i++) if (cap_w[i] == val) return i;
        return -1;
    endfunction

    function automatic int count_flags(input int from);
        int c = 0;
        for (int i = from; i < cap_n; i++) if (cap_f[i]) c++;
        return c;
    endfunction

    task automatic send_bits(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_bit = bits[i];
        end
    endtask

    task automatic send_char(input logic [9:0] c);
        send_bits({6'b0, c}, 10);
    endtask

    task automatic flush();
        send_char(D215);
        send_char(D102);
        send_char(D215);
    endtask

    // Reset and check the cleared outputs (R10).
    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        ser_bit = 1'b0;
        repeat (3) @(negedge clk);
        chk(rx_word == 10'h0, "R10 word", int'(rx_word), 0);
        chk(!comma_flag, "R10 flag", int'(comma_flag), 0);
        chk(!strb_even && strb_odd, "R10 strobes", int'({strb_even, strb_odd}), 1);
        rst_n = 1'b1;
    endtask

    // R3/R1/R2/R7: align enabled, comma at an odd offset, then an on-boundary K28.1.
    task automatic t_align_enabled();
        int s;
        int i;
        s = cap_n;
        send_bits(16'b101, 3);
        send_char(D215);
        send_char(K285N);
        send_char(D102);
        send_char(K281N);
        send_char(D215);
        flush();
        chk(cap_e[s] == 1'b1, "R7 first word even", int'(cap_e[s]), 1);
        i = find_word(s, K285N);
        chk(i >= 0, "R3 K28.5 aligned", i, 0);
        if (i >= 0) begin
            chk(cap_f[i], "R4 flag on comma word", int'(cap_f[i]), 1);
            chk(cap_w[i+1] == D102, "R2 next word", int'(cap_w[i+1]), int'(D102));
            chk(cap_w[i+2] == K281N && cap_f[i+2], "R1 K28.1 flagged",
                int'(cap_w[i+2]), int'(K281N));
        end
        chk(count_flags(s) == 2, "R4 flag count", count_flags(s), 2);
    endtask

    // R3/R8: realign to a new offset with positive-disparity comma.
    task automatic t_realign();
        int s;
        int i;
        s = cap_n;
        max_gap = 0;
        send_bits(16'b1010, 4);
        send_char(K285P);
        send_char(D102);
        flush();
        i = find_word(s, K285P);
        chk(i >= 0 && cap_f[i], "R3 realign K28.5+", i, 0);
        if (i >= 0) chk(cap_w[i+1] == D102, "R2 word after realign", int'(cap_w[i+1]), int'(D102));
        chk(max_gap > 10, "R8 level stretched", max_gap, 11);
        chk(max_gap <= 19, "R8 stretch bound", max_gap, 19);
    endtask

    // R5/R4: enable low after alignment; misaligned comma ignored, aligned one flagged.
    task automatic t_frozen();
        int s;
        int i;
        align_en = 1'b0;
        s = cap_n;
        send_bits(16'b10101, 5);
        send_char(K281N);
        send_char(D102);
        flush();
        chk(count_flags(s) == 0, "R5 no flag off boundary", count_flags(s), 0);
        chk(find_word(s, K281N) < 0, "R5 boundary kept", find_word(s, K281N), -1);
        s = cap_n;
        send_bits(16'b01010, 5);
        send_char(K287N);
        send_char(D215);
        flush();
        i = find_word(s, K287N);
        chk(i >= 0 && cap_f[i], "R4 K28.7 flagged with enable low", i, 0);
        align_en = 1'b1;
    endtask

    // R6/R10: after reset, enable low; first comma aligns, later one ignored.
    task automatic t_first_only();
        int s;
        int i;
        align_en = 1'b0;
        do_reset();
        s = cap_n;
        send_bits(16'b1010101, 7);
        send_char(D215);
        send_char(K285N);
        send_char(D102);
        flush();
        i = find_word(s, K285N);
        chk(i >= 0 && cap_f[i], "R6 first comma aligned", i, 0);
        s = cap_n;
        send_bits(16'b010, 3);
        send_char(K285N);
        send_char(D102);
        flush();
        chk(count_flags(s) == 0, "R6 later comma not flagged", count_flags(s), 0);
        chk(find_word(s, K285N) < 0, "R6 later comma not aligned", find_word(s, K285N), -1);
        align_en = 1'b1;
    endtask

    // R9: receiver not locked, no detection.
    task automatic t_unlocked();
        int s;
        rx_lock = 1'b0;
        do_reset();
        s = cap_n;
        send_bits(16'b101, 3);
        send_char(D215);
        send_char(K285N);
        send_char(D102);
        flush();
        chk(count_flags(s) == 0, "R9 no flag unlocked", count_flags(s), 0);
        chk(find_word(s, K285N) < 0, "R9 no alignment unlocked", find_word(s, K285N), -1);
        rx_lock = 1'b1;
    endtask

    initial begin
        do_reset();
        t_align_enabled();
        t_realign();
        t_frozen();
        t_first_only();
        t_unlocked();
        repeat (5) @(negedge clk);
        chk(short_gaps == 0, "R8 no short level", short_gaps, 0);
        chk(opp_errs == 0, "R7 strobes complementary", opp_errs, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual 0x1 expected 0x0");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule